// File: doc/BRIEF.md
# Global-History Bimodal Direction Predictor

This block guesses whether a conditional branch will be taken. Each branch address has its own short warm-up phase. A branch that has never been taken is predicted not-taken. Once it has been taken, it is predicted taken until it is first seen falling through. After that point, its prediction comes from a table of 2-bit saturating counters. That table is indexed by the outcomes of the most recent conditional branches, concatenated with low bits of the branch address.

Fetch logic presents a branch address on the lookup port and reads `pred_taken` combinationally in the same cycle. When a branch resolves, the back end presents its address and its real outcome on the resolve port. That one clock edge updates three things:

- the branch's phase,
- the counter addressed by the current history,
- the history register itself.

History is updated only at resolve, so it never holds speculative outcomes. For a full-size table, set `ADDR_HI_W` to 2. The index then becomes {addr[5:4], history[7:0], addr[3:0]} over 16384 counters.

Top module: `gbh_predictor`

## Requirements
- R1: After reset the history register is all zeros, every phase entry is never-taken (code 00) and every counter holds 1.
- R2: A branch in the never-taken phase is predicted not-taken. Its first taken resolve moves it to the taken-seen phase (code 01).
- R3: A branch in the taken-seen phase is predicted taken. Its first not-taken resolve moves it to table mode (code 10), and table mode is never left.
- R4: In table mode the prediction is taken exactly when the counter at index {addr[ADDR_LO_W+ADDR_HI_W-1:ADDR_LO_W], history, addr[ADDR_LO_W-1:0]} holds 2 or 3. The history here is the value current at lookup. A repeating 8-long outcome pattern is therefore learned perfectly.
- R5: On every resolve, whatever the branch's phase, the indexed counter increments on taken and decrements on not-taken. It saturates at 3 and at 0.
- R6: Each resolve shifts the outcome (1 = taken) into bit 0 of the history. Without a resolve the history holds.
- R7: Phase state is kept per address (all ADDR_W bits): training one address leaves the phase of another unchanged.
- R8: A lookup in the same cycle as a resolve sees the state before that resolve's update.
- R9: While lookup-valid is low, `pred_taken` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Address of the branch being looked up |
| rs_valid | input | 1 | Resolve event |
| rs_addr | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |
| pred_taken | output | 1 | Predicted direction, 1 = taken |

## Verification
The hardest state to reach from the ports is a single counter driven into saturation. The history enters the index, so a counter is hit twice in a row only when the history stays constant. The stimulus therefore resolves one branch the same way more than eight times, which pins the history at all ones or all zeros. It then keeps going so that the same counter is pushed well past its limit before its direction is read back. A repeating 8-outcome pattern and a randomized mixed stream are compared cycle by cycle against an arithmetic model of phases, counters and history.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        PH_NEVER = 2'b00,
        PH_SEEN  = 2'b01,
        PH_TABLE = 2'b10
    } phase_e;

    localparam logic [1:0] CTR_INIT = 2'd1;
    localparam logic [1:0] CTR_MAX  = 2'd3;
    localparam logic [1:0] CTR_MIN  = 2'd0;

    typedef struct packed {
        logic valid;
        logic taken;
    } outcome_t;

    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
        logic [1:0] n;
        n = c;
        if (taken && c != CTR_MAX) n = c + 2'd1;
        if (!taken && c != CTR_MIN) n = c - 2'd1;
        return n;
    endfunction

    function automatic phase_e phase_step(input phase_e p, input logic taken);
        phase_e n;
        n = p;
        case (p)
            PH_NEVER: if (taken)  n = PH_SEEN;
            PH_SEEN:  if (!taken) n = PH_TABLE;
            default:  n = PH_TABLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bp_history.sv
module bp_history #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bp_pkg::outcome_t  upd,
    output logic [HIST_W-1:0] hist_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (upd.valid) begin
            hist_q <= {hist_q[HIST_W-2:0], upd.taken};
        end
    end

    // R6: outcome lands in bit 0, older bits move up
    a_r6_shift_in: assert property (@(posedge clk) disable iff (rst)
        upd.valid |=> (hist_q[0] == $past(upd.taken)) &&
                      (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !upd.valid |=> $stable(hist_q));
endmodule

// File: rtl/bp_phase_table.sv
module bp_phase_table #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output bp_pkg::phase_e   rd_phase,
    input  logic [IDX_W-1:0] wr_idx,
    input  bp_pkg::outcome_t wr
);
    import bp_pkg::*;
    localparam int DEPTH = 1 << IDX_W;

    phase_e ph_q [DEPTH];
    phase_e wr_cur;

    assign rd_phase = ph_q[rd_idx];
    assign wr_cur   = ph_q[wr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ph_q[i] <= PH_NEVER;
        end else if (wr.valid) begin
            ph_q[wr_idx] <= phase_step(wr_cur, wr.taken);
        end
    end

    // R3: taken-seen plus a fall-through enters table mode
    a_r3_enter_table: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr_cur == PH_SEEN && !wr.taken) |=> ph_q[$past(wr_idx)] == PH_TABLE);
    // R3: table mode is sticky
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr_cur == PH_TABLE) |=> ph_q[$past(wr_idx)] == PH_TABLE);
    // R2: first taken leaves never-taken
    a_r2_first_taken: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr_cur == PH_NEVER && wr.taken) |=> ph_q[$past(wr_idx)] == PH_SEEN);
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic [IDX_W-1:0] wr_idx,
    input  bp_pkg::outcome_t wr
);
    import bp_pkg::*;
    localparam int DEPTH = 1 << IDX_W;

    logic [1:0] ctr_q [DEPTH];
    logic [1:0] wr_cur;

    assign rd_ctr = ctr_q[rd_idx];
    assign wr_cur = ctr_q[wr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
        end else if (wr.valid) begin
            ctr_q[wr_idx] <= ctr_step(wr_cur, wr.taken);
        end
    end

    // R5: saturation at both ends
    a_r5_sat_high: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.taken && wr_cur == CTR_MAX) |=> ctr_q[$past(wr_idx)] == CTR_MAX);
    a_r5_sat_low: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && !wr.taken && wr_cur == CTR_MIN) |=> ctr_q[$past(wr_idx)] == CTR_MIN);
endmodule

// File: rtl/gbh_predictor.sv
module gbh_predictor #(
    parameter int ADDR_W    = 8,
    parameter int HIST_W    = 8,
    parameter int ADDR_LO_W = 4,
    parameter int ADDR_HI_W = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_addr,
    input  logic              rs_taken,
    output logic              pred_taken
);
    import bp_pkg::*;
    localparam int CIDX_W = ADDR_HI_W + HIST_W + ADDR_LO_W;

    outcome_t          res;
    logic [HIST_W-1:0] hist;
    logic [CIDX_W-1:0] lk_cidx;
    logic [CIDX_W-1:0] rs_cidx;
    phase_e            lk_phase;
    logic [1:0]        lk_ctr;

    assign res.valid = rs_valid;
    assign res.taken = rs_taken;

    generate
        if (ADDR_HI_W > 0) begin : g_hi_bits
            assign lk_cidx = {lk_addr[ADDR_LO_W +: ADDR_HI_W], hist, lk_addr[ADDR_LO_W-1:0]};
            assign rs_cidx = {rs_addr[ADDR_LO_W +: ADDR_HI_W], hist, rs_addr[ADDR_LO_W-1:0]};
        end else begin : g_lo_only
            assign lk_cidx = {hist, lk_addr[ADDR_LO_W-1:0]};
            assign rs_cidx = {hist, rs_addr[ADDR_LO_W-1:0]};
        end
    endgenerate

    bp_history #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst(rst), .upd(res), .hist_q(hist)
    );

    bp_phase_table #(.IDX_W(ADDR_W)) u_phase (
        .clk(clk), .rst(rst),
        .rd_idx(lk_addr), .rd_phase(lk_phase),
        .wr_idx(rs_addr), .wr(res)
    );

    bp_counter_table #(.IDX_W(CIDX_W)) u_ctr (
        .clk(clk), .rst(rst),
        .rd_idx(lk_cidx), .rd_ctr(lk_ctr),
        .wr_idx(rs_cidx), .wr(res)
    );

    always_comb begin
        pred_taken = 1'b0;
        if (lk_valid) begin
            case (lk_phase)
                PH_NEVER: pred_taken = 1'b0;
                PH_SEEN:  pred_taken = 1'b1;
                default:  pred_taken = lk_ctr[1];
            endcase
        end
    end

    // R9: no lookup, no taken prediction
    a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !pred_taken);
    // R2: never-taken branches fall through
    a_r2_never_nt: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_phase == PH_NEVER) |-> !pred_taken);
    // R3: taken-seen branches are taken
    a_r3_seen_t: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_phase == PH_SEEN) |-> pred_taken);
endmodule

// File: tb/test_gbh_predictor.sv
module test_gbh_predictor;
    localparam int ADDR_W = 8;
    localparam int HIST_W = 8;
    localparam int LO_W   = 4;
    localparam int CDEPTH = 1 << (HIST_W + LO_W);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic rs_valid = 1'b0;
    logic [ADDR_W-1:0] rs_addr = '0;
    logic rs_taken = 1'b0;
    logic pred_taken;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    // model state: 0 never, 1 seen, 2 table
    int          m_ph  [1 << ADDR_W];
    logic [1:0]  m_ctr [CDEPTH];
    logic [HIST_W-1:0] m_hist;

    always #4 clk = ~clk;

    gbh_predictor i_gbh_predictor (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
        .pred_taken(pred_taken)
    );

    function automatic int cidx(input logic [ADDR_W-1:0] a);
        return (int'(m_hist) << LO_W) + int'(a[LO_W-1:0]);
    endfunction

    function automatic logic model_pred(input logic v, input logic [ADDR_W-1:0] a);
        if (!v) return 1'b0;
        if (m_ph[a] == 0) return 1'b0;
        if (m_ph[a] == 1) return 1'b1;
        return m_ctr[cidx(a)] >= 2'd2;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < (1 << ADDR_W); i++) m_ph[i] = 0;
        for (int i = 0; i < CDEPTH; i++) m_ctr[i] = 2'd1;
        m_hist = '0;
    endtask

    task automatic model_resolve(input logic [ADDR_W-1:0] a, input logic t);
        int k;
        k = cidx(a);
        if (t && m_ctr[k] != 2'd3) m_ctr[k] = m_ctr[k] + 2'd1;
        if (!t && m_ctr[k] != 2'd0) m_ctr[k] = m_ctr[k] - 2'd1;
        if (m_ph[a] == 0 && t) m_ph[a] = 1;
        else if (m_ph[a] == 1 && !t) m_ph[a] = 2;
        m_hist = {m_hist[HIST_W-2:0], t};
    endtask

    task automatic check(input logic got, input logic exp, input string tag);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: pred_taken=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    // called at a falling edge; drives, checks, clocks, returns at next falling edge
    task automatic cyc(input logic lv, input logic [ADDR_W-1:0] la,
                       input logic rv, input logic [ADDR_W-1:0] ra, input logic rt,
                       input string tag, output logic got);
        lk_valid = lv; lk_addr = la; rs_valid = rv; rs_addr = ra; rs_taken = rt;
        #1;
        got = pred_taken;
        check(got, model_pred(lv, la), tag);
        @(posedge clk);
        if (rv) model_resolve(ra, rt);
        @(negedge clk);
    endtask

    task automatic look(input logic [ADDR_W-1:0] a, input logic exp, input string tag);
        logic g;
        cyc(1'b1, a, 1'b0, '0, 1'b0, tag, g);
        check(g, exp, tag);
    endtask

    task automatic resolve(input logic [ADDR_W-1:0] a, input logic t, input string tag);
        logic g;
        cyc(1'b1, a, 1'b1, a, t, tag, g);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog: run did not complete, expected end of stimulus");
        finish_run();
    end

    initial begin
        logic g;
        bit pat [8] = '{1, 1, 0, 1, 0, 0, 1, 0};
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1/R2: fresh state predicts not-taken everywhere
        for (int a = 0; a < 256; a += 17) look(a[7:0], 1'b0, "R1 reset phase");

        // R9: no lookup -> 0
        cyc(1'b0, 8'h10, 1'b0, '0, 1'b0, "R9 idle", g);

        // R2/R3 warm-up of one branch at 0x10
        look(8'h10, 1'b0, "R2 never");
        resolve(8'h10, 1'b1, "R2 first taken");
        look(8'h10, 1'b1, "R3 seen");
        cyc(1'b0, 8'h10, 1'b0, '0, 1'b0, "R9 idle while seen", g);
        check(g, 1'b0, "R9 idle while seen");
        resolve(8'h10, 1'b1, "R3 still seen");
        look(8'h10, 1'b1, "R3 seen after 2nd taken");
        resolve(8'h10, 1'b0, "R3 first fall-through");
        // history 0b110, counter index 96 untouched -> reset value 1 -> not-taken
        look(8'h10, 1'b0, "R1 R4 counter init");
        // R7: neighbour untouched
        look(8'h11, 1'b0, "R7 neighbour phase");

        // R8: same-cycle resolve and lookup of a fresh branch
        cyc(1'b1, 8'h20, 1'b1, 8'h20, 1'b1, "R8 pre-update", g);
        check(g, 1'b0, "R8 pre-update");
        look(8'h20, 1'b1, "R8 post-update");

        // R5 high saturation: branch 0x23 in table mode, many takens
        resolve(8'h23, 1'b0, "R5 setup");
        resolve(8'h23, 1'b1, "R5 setup");
        resolve(8'h23, 1'b0, "R5 to table");
        for (int i = 0; i < 24; i++) resolve(8'h23, 1'b1, "R5 train up");
        look(8'h23, 1'b1, "R5 saturate high");
        // R5 low saturation: history pins to zero
        for (int i = 0; i < 24; i++) resolve(8'h23, 1'b0, "R5 train down");
        look(8'h23, 1'b0, "R5 saturate low");
        resolve(8'h23, 1'b1, "R5 one up from 0");

        // R4: repeating 8-long pattern learned
        resolve(8'h35, 1'b1, "R4 setup");
        resolve(8'h35, 1'b0, "R4 to table");
        for (int r = 0; r < 40; r++) begin
            for (int j = 0; j < 8; j++) begin
                cyc(1'b1, 8'h35, 1'b1, 8'h35, pat[j], "R4 pattern", g);
                if (r >= 30) check(g, pat[j], "R4 learned");
            end
        end

        // R6/R4/R8 randomized mix against the model
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] la, ra;
            logic lv, rv, rt;
            la = 8'h40 + 8'($urandom % 12);
            ra = 8'h40 + 8'($urandom % 12);
            lv = ($urandom % 4) != 0;
            rv = ($urandom % 3) != 0;
            rt = (ra[0]) ? (($urandom % 8) != 0) : (($urandom % 3) == 0);
            cyc(lv, la, rv, ra, rt, "R6 random mix", g);
        end

        // R1: reset again restores initial state
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        look(8'h10, 1'b0, "R1 after re-reset");
        look(8'h20, 1'b0, "R1 after re-reset");

        lk_valid = 1'b0; rs_valid = 1'b0;
        finish_run();
    end
endmodule